// File: doc/BRIEF.md
# Bit-Slip Deserializer

This block turns a serial bit stream, one bit per clock, into parallel words whose width is chosen at the configuration inputs. A word boundary comes every `n` clocks, where `n` is the effective word ratio. That boundary serves as the parallel clock of the receiver. At each boundary the block publishes the assembled word and pulses a one-cycle strobe. The bit received first lands in the most significant used position.

To move the word boundary, core logic raises an alignment request. The request is sampled only at word boundaries, so it lives in the parallel domain. Each rising level adds one bit-time of delay to the serial stream ahead of the assembler. The delay is taken from a tapped delay line. The count of added bits wraps to zero after a configurable rollover point, and a flag reports when the count sits at that point. The first word built after a slip is not strobed. Realigned data is therefore published two boundaries after the one that accepted the request.

The request handling is a three-state machine. In IDLE, a boundary that sees the request high takes transition T_SLIP to SETTLE and applies one slip. In SETTLE, the strobe for the next boundary is suppressed. At that boundary the machine takes T_REARM back to IDLE if the request is low, or T_KEEP to HOLD if it is still high. In HOLD, the machine waits for a boundary with the request low and then takes T_RELEASE back to IDLE.

Top module: `slip_deser`

## Requirements
- R1: With slip count `s` and ratio `n`, the word captured at boundary edge `E` has bit `n-1-j` (j = 0..n-1) equal to the serial input sampled at edge `E-n+j-s`. Bits `n` and above are zero, and inputs sampled before reset release count as zero.
- R2: The effective ratio is `cfg_ratio` clamped to 3..10. A value below 3 acts as 3 and a value above 10 acts as 10.
- R3: The alignment request is sampled only at word-boundary edges, and `par_stb` is high for one cycle after each boundary whose word is published. Without slips, strobes are exactly `n` cycles apart.
- R4: A boundary that takes a request adds exactly one bit of delay and still publishes the old-alignment word. The next boundary's word is suppressed. The following boundary publishes realigned data, so consecutive strobes are `2n` cycles apart.
- R5: The slip count runs 0..`roll`, where `roll` is `cfg_roll` clamped to 1..11. A slip taken at count `roll` returns the count to 0, whatever the ratio.
- R6: `slip_at_max` is high exactly while the slip count equals `roll`, and it changes at the same edge as the count.
- R7: A request held high over many boundaries causes one slip only. A new slip needs at least one boundary that samples the request low, and one such boundary is enough.
- R8: Reset clears the delay line, the slip count, `slip_at_max`, `par_word` and `par_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial data, one bit per clock |
| cfg_ratio | input | 4 | Word ratio (clamped 3..10), held static |
| cfg_roll | input | 4 | Slip rollover point (clamped 1..11), held static |
| align_req | input | 1 | Realignment request, sampled at word boundaries |
| par_word | output | 10 | Last published word, LSB-aligned |
| par_stb | output | 1 | One-cycle pulse when a word is published |
| slip_at_max | output | 1 | Slip count is at the rollover point |

## Verification
A slip and a word capture share the same boundary edge. The bench provokes this by raising the request right after a strobe, which makes the next boundary do both. The bench then checks that the word published at that edge still carries the old alignment, that the strobe for the next boundary is absent (a `2n` gap), and that the word after it matches the stream delayed by one more bit. The rollover and the flag update land on that same edge. The bench judges them at the strobe that closes the slip boundary, across every ratio and several rollover points, including the clamped ones.

// File: rtl/slip_deser_pkg.sv
package slip_deser_pkg;

    localparam int DFLT_WORD_MIN = 3;
    localparam int DFLT_WORD_MAX = 10;
    localparam int DFLT_ROLL_MIN = 1;
    localparam int DFLT_ROLL_MAX = 11;

    typedef enum logic [1:0] {
        ALN_IDLE   = 2'd0,
        ALN_SETTLE = 2'd1,
        ALN_HOLD   = 2'd2
    } aln_state_e;

endpackage

// File: rtl/desr_delay_line.sv
module desr_delay_line #(
    parameter int TAPS  = 12,
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    input  logic [SEL_W-1:0] sel,
    output logic             dout
);

    logic [TAPS-1:0] line_q;
    logic [TAPS-1:0] hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '0;
        end else begin
            line_q <= {line_q[TAPS-2:0], din};
        end
    end

    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        assign hit[t] = line_q[t] & (sel == SEL_W'(t));
    end

    assign dout = |hit;

    // a tap index beyond the line would read nothing
    always_ff @(posedge clk) begin
        if (rst_n) begin
            AST_TAP_IN_RANGE: assert (int'(sel) < TAPS); // R5
        end
    end

endmodule

// File: rtl/desr_align_fsm.sv
module desr_align_fsm
    import slip_deser_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             align,
    input  logic [CNT_W-1:0] roll,
    output logic             withhold,
    output logic [CNT_W-1:0] slip_cnt,
    output logic             at_max
);

    aln_state_e state_q;
    aln_state_e state_d;
    logic       take_slip;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ALN_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d   = state_q;
        take_slip = 1'b0;
        unique case (state_q)
            ALN_IDLE: begin
                if (tick && align) begin
                    state_d   = ALN_SETTLE;   // T_SLIP
                    take_slip = 1'b1;
                end
            end
            ALN_SETTLE: begin
                if (tick) begin
                    state_d = align ? ALN_HOLD : ALN_IDLE;  // T_KEEP / T_REARM
                end
            end
            ALN_HOLD: begin
                if (tick && !align) begin
                    state_d = ALN_IDLE;       // T_RELEASE
                end
            end
            default: state_d = ALN_IDLE;
        endcase
    end

    // outputs
    assign withhold = (state_q == ALN_SETTLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slip_cnt <= '0;
            at_max   <= 1'b0;
        end else if (take_slip) begin
            if (slip_cnt >= roll) begin
                slip_cnt <= '0;
                at_max   <= 1'b0;
            end else begin
                slip_cnt <= slip_cnt + CNT_W'(1);
                at_max   <= ((slip_cnt + CNT_W'(1)) == roll);
            end
        end
    end

    AST_SLIP_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(slip_cnt)); // R3
    AST_SLIP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(slip_cnt) |-> (slip_cnt == $past(slip_cnt) + CNT_W'(1) || slip_cnt == '0)); // R5
    AST_SLIP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        slip_cnt <= roll); // R5
    AST_HOLD_NO_SLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ALN_HOLD) |=> $stable(slip_cnt)); // R7
    AST_MAX_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        at_max |-> (slip_cnt == roll)); // R6

endmodule

// File: rtl/desr_word_asm.sv
module desr_word_asm #(
    parameter int WORD_MAX = 10,
    parameter int RATIO_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                din,
    input  logic [RATIO_W-1:0]  ratio,
    input  logic                withhold,
    output logic                tick,
    output logic [WORD_MAX-1:0] word,
    output logic                stb
);

    logic [RATIO_W-1:0]  bit_cnt;
    logic [WORD_MAX-1:0] shift_q;
    logic [WORD_MAX-1:0] keep;
    logic [WORD_MAX-1:0] capture;

    for (genvar i = 0; i < WORD_MAX; i++) begin : g_keep
        assign keep[i] = (ratio > RATIO_W'(i));
    end

    assign tick    = (bit_cnt >= ratio - RATIO_W'(1));
    assign capture = {shift_q[WORD_MAX-2:0], din} & keep;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shift_q <= '0;
            word    <= '0;
            stb     <= 1'b0;
        end else begin
            bit_cnt <= tick ? '0 : bit_cnt + RATIO_W'(1);
            shift_q <= {shift_q[WORD_MAX-2:0], din};
            stb     <= tick && !withhold;
            if (tick && !withhold) begin
                word <= capture;
            end
        end
    end

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> !stb); // R3
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        stb |-> ((word >> ratio) == '0)); // R1

endmodule

// File: rtl/slip_deser.sv
module slip_deser
    import slip_deser_pkg::*;
#(
    parameter int WORD_MIN = DFLT_WORD_MIN,
    parameter int WORD_MAX = DFLT_WORD_MAX,
    parameter int ROLL_MIN = DFLT_ROLL_MIN,
    parameter int ROLL_MAX = DFLT_ROLL_MAX,
    parameter int RATIO_W  = $clog2(WORD_MAX + 1),
    parameter int CNT_W    = $clog2(ROLL_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ser_in,
    input  logic [RATIO_W-1:0]  cfg_ratio,
    input  logic [CNT_W-1:0]    cfg_roll,
    input  logic                align_req,
    output logic [WORD_MAX-1:0] par_word,
    output logic                par_stb,
    output logic                slip_at_max
);

    localparam int TAPS = ROLL_MAX + 1;

    logic [RATIO_W-1:0] ratio_eff;
    logic [CNT_W-1:0]   roll_eff;
    logic [CNT_W-1:0]   slip_cnt;
    logic               slipped_bit;
    logic               tick;
    logic               withhold;

    always_comb begin
        if (cfg_ratio < RATIO_W'(WORD_MIN))      ratio_eff = RATIO_W'(WORD_MIN);
        else if (cfg_ratio > RATIO_W'(WORD_MAX)) ratio_eff = RATIO_W'(WORD_MAX);
        else                                     ratio_eff = cfg_ratio;
    end

    always_comb begin
        if (cfg_roll < CNT_W'(ROLL_MIN))      roll_eff = CNT_W'(ROLL_MIN);
        else if (cfg_roll > CNT_W'(ROLL_MAX)) roll_eff = CNT_W'(ROLL_MAX);
        else                                  roll_eff = cfg_roll;
    end

    desr_delay_line #(
        .TAPS  (TAPS),
        .SEL_W (CNT_W)
    ) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ser_in),
        .sel   (slip_cnt),
        .dout  (slipped_bit)
    );

    desr_align_fsm #(
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .align    (align_req),
        .roll     (roll_eff),
        .withhold (withhold),
        .slip_cnt (slip_cnt),
        .at_max   (slip_at_max)
    );

    desr_word_asm #(
        .WORD_MAX (WORD_MAX),
        .RATIO_W  (RATIO_W)
    ) u_asm (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (slipped_bit),
        .ratio    (ratio_eff),
        .withhold (withhold),
        .tick     (tick),
        .word     (par_word),
        .stb      (par_stb)
    );

    AST_NO_STB_WHEN_SETTLING: assert property (@(posedge clk) disable iff (!rst_n)
        (withhold && tick) |=> !par_stb); // R4

endmodule

// File: tb/slip_deser_test.sv
`timescale 1ns/1ps
module slip_deser_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_in = 1'b0;
    logic [3:0] cfg_ratio = 4'd4;
    logic [3:0] cfg_roll = 4'd3;
    logic       align_req = 1'b0;
    logic [9:0] par_word;
    logic       par_stb;
    logic       slip_at_max;

    int tests = 0;
    int fails = 0;
    int k = 0;
    int e_obs = 0;
    int r_eff = 4;
    int roll_m = 3;
    int slip_m = 0;

    always #2.5 clk = ~clk;

    slip_deser uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ser_in      (ser_in),
        .cfg_ratio   (cfg_ratio),
        .cfg_roll    (cfg_roll),
        .align_req   (align_req),
        .par_word    (par_word),
        .par_stb     (par_stb),
        .slip_at_max (slip_at_max)
    );

    function automatic logic fbit(int n);
        logic [31:0] v;
        if (n < 0) return 1'b0;
        v = n * 32'd1103515245 + 32'd12345;
        return v[16] ^ v[9];
    endfunction

    function automatic logic [9:0] expw(int e, int n, int s);
        logic [9:0] w = '0;
        for (int j = 0; j < n; j++) w[n-1-j] = fbit(e - n + j - s);
        return w;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        align_req = 1'b0;
        ser_in = 1'b0;
        repeat (3) @(negedge clk);
        chk(par_stb == 1'b0, "R8 strobe after reset", int'(par_stb), 0);
        chk(slip_at_max == 1'b0, "R8 max flag after reset", int'(slip_at_max), 0);
        chk(par_word == '0, "R8 word after reset", int'(par_word), 0);
        rst_n = 1'b1;
        ser_in = fbit(0);
        k = 1;
        slip_m = 0;
    endtask

    task automatic get_word(input int gap_exp, input string tag);
        int  g;
        logic s;
        g = 0;
        s = 1'b0;
        while (!s && g < 64) begin
            @(negedge clk);
            s = par_stb;
            e_obs = k - 1;
            ser_in = fbit(k);
            k++;
            g++;
        end
        chk(s, {tag, " strobe seen"}, int'(s), 1);
        if (gap_exp > 0) chk(g == gap_exp, {tag, " strobe gap"}, g, gap_exp);
        chk(par_word == expw(e_obs, r_eff, slip_m), {tag, " word"},
            int'(par_word), int'(expw(e_obs, r_eff, slip_m)));
    endtask

    // one request pulse; long_hold keeps it high over extra boundaries
    task automatic do_slip(input bit long_hold);
        align_req = 1'b1;
        get_word(r_eff, "R4 old-alignment word");
        slip_m = (slip_m >= roll_m) ? 0 : slip_m + 1;
        chk(slip_at_max == (slip_m == roll_m), "R6 max flag at slip edge",
            int'(slip_at_max), int'(slip_m == roll_m));
        if (!long_hold) begin
            align_req = 1'b0;
            get_word(2 * r_eff, "R4 realigned word");
        end else begin
            get_word(2 * r_eff, "R4 realigned word");
            get_word(r_eff, "R7 held request no slip");
            get_word(r_eff, "R7 held request no slip");
            align_req = 1'b0;
            get_word(r_eff, "R7 released");
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int ri = 2; ri <= 11; ri++) begin
            for (int qi = 0; qi < 4; qi++) begin
                int rv;
                rv = (qi == 0) ? 0 : (qi == 1) ? 3 : (qi == 2) ? 11 : 14;
                cfg_ratio = 4'(ri);
                cfg_roll = 4'(rv);
                // R2 and R5 clamps computed independently
                r_eff = (ri < 3) ? 3 : (ri > 10) ? 10 : ri;
                roll_m = (rv < 1) ? 1 : (rv > 11) ? 11 : rv;
                do_reset();
                get_word(0, "R1 first word");
                get_word(r_eff, "R3 steady word");
                repeat (roll_m) do_slip(1'b0);
                chk(slip_at_max == 1'b1, "R6 at rollover point", int'(slip_at_max), 1);
                do_reset();
                get_word(0, "R8 first word after reset");
                get_word(r_eff, "R1 word after reset");
                repeat (roll_m + 1) do_slip(1'b0);
                chk(slip_m == 0, "R5 wrapped to zero", slip_m, 0);
                chk(slip_at_max == 1'b0, "R5 flag clear after wrap", int'(slip_at_max), 0);
                do_slip(1'b1);
            end
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule